// File: doc/BRIEF.md
# Playback Format Decoder and Interrupt Counter

This block sits beside the playback datapath of an audio codec. It turns the packed playback format byte into a sample rate in hertz, a channel count, a sample encoding and a byte shift, and it flags rate or encoding codes that cannot be played. It drives the playback DMA request from the playback enable and the error flag. It also counts the bytes the datapath reports as moved, compares that count with a programmed 16-bit base count scaled to bytes, and raises a playback interrupt when the two meet.

The register port that owns the format, configuration and count registers feeds their current values in as plain inputs. The interrupt flags are shared with that port: it can write the playback flag directly or acknowledge both flags at once, and it reads the flags back from the outputs.

Top module: `pbk_fmt_irq`

## Requirements
- R1: The rate is selected by format bit 0 (crystal) and bits 3:1 (index). Crystal 0 gives 8000, 16000, 27420, 32000, none, none, 48000, 9000 Hz for indexes 0 to 7. Crystal 1 gives 5510, 11025, 18900, 22050, 37800, 44100, 33075, 6620 Hz. An index without a rate outputs 0 Hz and sets the error flag.
- R2: The encoding code is format bits 7:5, with bit 7 forced to 0 unless wide mode is set. The output code is 0 unsigned 8-bit, 1 mu-law, 2 signed 16-bit little-endian, 3 A-law, 4 signed 16-bit big-endian (from input code 6). Format bit 4 drives the stereo output.
- R3: Input codes 4, 5 and 7 (reachable only in wide mode) output code 7 and set the error flag.
- R4: The byte shift is 1 for stereo and 0 for mono with 8-bit, mu-law or A-law samples. It is 2 for stereo and 1 for mono with 16-bit samples. It is 0 for a rejected code.
- R5: The DMA request is a register. After each clock edge it equals (playback enable AND NOT error flag) as sampled at that edge.
- R6: A rising edge of playback enable clears the byte counter.
- R7: The terminal count is the 16-bit base count {upper, lower} shifted left by the byte shift. While interrupts are enabled and the DMA request is high, each strobe advances the counter. On the strobe that brings the count to the terminal count, INT, PI and the interrupt line go high at that clock edge and the counter returns to 0.
- R8: While interrupts are disabled, strobes are ignored and the counter holds its value.
- R9: A flag write sets PI to the written value. If PI was 1 and is written 0, INT and the interrupt line fall too. Writing 1 sets PI but not INT.
- R10: An acknowledge clears INT and PI. A terminal hit in the same cycle wins and leaves both set.
- R11: Strobes are ignored while the DMA request is low or the terminal count is 0.
- R12: After reset the DMA request, INT, PI and the interrupt line are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fmt_reg_i | input | 8 | Playback rate and format byte |
| wide_mode_i | input | 1 | Extended mode; unmasks format bit 7 |
| play_en_i | input | 1 | Playback enable |
| irq_en_i | input | 1 | Interrupt enable |
| base_hi_i | input | 8 | Upper byte of base count |
| base_lo_i | input | 8 | Lower byte of base count |
| xfer_stb_i | input | 1 | One byte moved by the datapath |
| flag_wr_i | input | 1 | Write strobe for the PI flag |
| flag_wr_pi_i | input | 1 | Value written to PI |
| ack_i | input | 1 | Acknowledge; clears INT and PI |
| rate_hz_o | output | 16 | Decoded sample rate, 0 when invalid |
| stereo_o | output | 1 | Two channels |
| sample_fmt_o | output | 3 | Decoded encoding code |
| byte_shift_o | output | 2 | Base-count scaling shift |
| fmt_err_o | output | 1 | Rate or encoding rejected |
| dma_req_o | output | 1 | Playback DMA request |
| irq_o | output | 1 | Interrupt line |
| int_flag_o | output | 1 | INT status flag |
| pi_flag_o | output | 1 | Playback interrupt flag |

## Verification
The bench steps through every rate slot, including the two empty crystal-0 slots, and checks the format code with wide mode both set and clear. Code 6 must read as little-endian 16-bit when wide mode is clear. A design that skips this masking reports big-endian there. The bench also checks the 16-bit stereo case, where the terminal count is four times the base. A wrong shift fires the interrupt at the wrong strobe.

Restarting playback partway through a count must start again from zero, or the interrupt arrives early. Strobes while interrupts are disabled must leave the count frozen, which shows up as the exact strobe on which the interrupt later fires. A design that lets an acknowledge win over a simultaneous hit loses that interrupt. A design that raises INT on a write of PI=1 leaves the line high with no transfer done.

// File: rtl/pbk_fmt_pkg.sv
package pbk_fmt_pkg;

   localparam int RATE_W = 16;

   typedef enum logic [2:0] {
      SF_U8    = 3'd0,
      SF_ULAW  = 3'd1,
      SF_S16LE = 3'd2,
      SF_ALAW  = 3'd3,
      SF_S16BE = 3'd4,
      SF_BAD   = 3'd7
   } samp_fmt_e;

   // Rate in Hz for crystal/index; 0 marks an empty slot.
   function automatic logic [RATE_W-1:0] rate_lookup(input logic xtal, input logic [2:0] idx);
      logic [RATE_W-1:0] r;
      case ({xtal, idx})
         4'h0: r = 16'd8000;
         4'h1: r = 16'd16000;
         4'h2: r = 16'd27420;
         4'h3: r = 16'd32000;
         4'h4: r = 16'd0;
         4'h5: r = 16'd0;
         4'h6: r = 16'd48000;
         4'h7: r = 16'd9000;
         4'h8: r = 16'd5510;
         4'h9: r = 16'd11025;
         4'hA: r = 16'd18900;
         4'hB: r = 16'd22050;
         4'hC: r = 16'd37800;
         4'hD: r = 16'd44100;
         4'hE: r = 16'd33075;
         default: r = 16'd6620;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/pbk_fmt_decode.sv
module pbk_fmt_decode
   import pbk_fmt_pkg::*;
(
   input  logic [7:0]        fmt_reg_i,
   input  logic              wide_mode_i,
   output logic [RATE_W-1:0] rate_hz_o,
   output logic              stereo_o,
   output samp_fmt_e         sample_fmt_o,
   output logic [1:0]        byte_shift_o,
   output logic              fmt_err_o
);
   logic       xtal;
   logic [2:0] idx;
   logic [2:0] code;
   logic       rate_bad;

   assign xtal     = fmt_reg_i[0];
   assign idx      = fmt_reg_i[3:1];
   assign stereo_o = fmt_reg_i[4];
   assign code     = {fmt_reg_i[7] & wide_mode_i, fmt_reg_i[6:5]};

   assign rate_hz_o = rate_lookup(xtal, idx);
   assign rate_bad  = ~xtal & (idx == 3'd4 || idx == 3'd5);

   always_comb begin
      case (code)
         3'd0:    sample_fmt_o = SF_U8;
         3'd1:    sample_fmt_o = SF_ULAW;
         3'd2:    sample_fmt_o = SF_S16LE;
         3'd3:    sample_fmt_o = SF_ALAW;
         3'd6:    sample_fmt_o = SF_S16BE;
         default: sample_fmt_o = SF_BAD;
      endcase
   end

   always_comb begin
      case (sample_fmt_o)
         SF_S16LE, SF_S16BE: byte_shift_o = stereo_o ? 2'd2 : 2'd1;
         SF_BAD:             byte_shift_o = 2'd0;
         default:            byte_shift_o = stereo_o ? 2'd1 : 2'd0;
      endcase
   end

   assign fmt_err_o = rate_bad | (sample_fmt_o == SF_BAD);

   // R3
   always_comb begin
      if (!wide_mode_i) reject_needs_wide_chk: assert (sample_fmt_o != SF_BAD);
   end
endmodule

// File: rtl/pbk_term_counter.sv
module pbk_term_counter #(
   parameter int BASE_W = 16,
   parameter int CNT_W  = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              stb_i,
   input  logic              run_i,
   input  logic [BASE_W-1:0] base_i,
   input  logic [1:0]        shift_i,
   output logic              hit_o
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] term;
   logic [CNT_W-1:0] cnt_inc;
   logic             adv;

   initial begin
      if (CNT_W < BASE_W + 2) $fatal(1, "counter too narrow for shifted base");
   end

   assign term    = CNT_W'(base_i) << shift_i;
   assign cnt_inc = cnt_q + 1'b1;
   assign adv     = stb_i & run_i & (term != '0) & ~start_i;
   assign hit_o   = adv & (cnt_inc == term);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (start_i)  cnt_q <= '0;
      else if (hit_o)    cnt_q <= '0;
      else if (adv)      cnt_q <= cnt_inc;
   end

   // R6
   start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> cnt_q == '0);
   // R7
   hit_rewinds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |=> cnt_q == '0);
   // R8
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !start_i) |=> $stable(cnt_q));
endmodule

// File: rtl/pbk_irq_flags.sv
module pbk_irq_flags #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hit_i,
   input  logic ack_i,
   input  logic wr_i,
   input  logic wr_pi_i,
   output logic int_o,
   output logic pi_o
);
   logic int_q, pi_q, int_d, pi_d;

   generate
      if (SET_WINS) begin : g_set_wins
         always_comb begin
            pi_d  = pi_q;
            int_d = int_q;
            if (wr_i) begin
               pi_d = wr_pi_i;
               if (pi_q && !wr_pi_i) int_d = 1'b0;
            end
            if (ack_i) begin
               pi_d  = 1'b0;
               int_d = 1'b0;
            end
            if (hit_i) begin
               pi_d  = 1'b1;
               int_d = 1'b1;
            end
         end
      end else begin : g_clear_wins
         always_comb begin
            pi_d  = pi_q | hit_i;
            int_d = int_q | hit_i;
            if (wr_i) begin
               pi_d = wr_pi_i;
               if ((pi_q || hit_i) && !wr_pi_i) int_d = 1'b0;
            end
            if (ack_i) begin
               pi_d  = 1'b0;
               int_d = 1'b0;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         int_q <= 1'b0;
         pi_q  <= 1'b0;
      end else begin
         int_q <= int_d;
         pi_q  <= pi_d;
      end
   end

   assign int_o = int_q;
   assign pi_o  = pi_q;

   // R9
   int_implies_pi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int_q |-> pi_q);
   // R9
   pi_fall_drops_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pi_q) |-> !int_q);
   // R10
   ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !hit_i) |=> (!int_q && !pi_q));
endmodule

// File: rtl/pbk_fmt_irq.sv
module pbk_fmt_irq
   import pbk_fmt_pkg::*;
#(
   parameter int BASE_W       = 16,
   parameter int CNT_W        = 18,
   parameter bit HIT_SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        fmt_reg_i,
   input  logic              wide_mode_i,
   input  logic              play_en_i,
   input  logic              irq_en_i,
   input  logic [BASE_W/2-1:0] base_hi_i,
   input  logic [BASE_W/2-1:0] base_lo_i,
   input  logic              xfer_stb_i,
   input  logic              flag_wr_i,
   input  logic              flag_wr_pi_i,
   input  logic              ack_i,
   output logic [RATE_W-1:0] rate_hz_o,
   output logic              stereo_o,
   output logic [2:0]        sample_fmt_o,
   output logic [1:0]        byte_shift_o,
   output logic              fmt_err_o,
   output logic              dma_req_o,
   output logic              irq_o,
   output logic              int_flag_o,
   output logic              pi_flag_o
);
   localparam int HALF_W = BASE_W / 2;

   initial begin
      if (BASE_W % 2 != 0) $fatal(1, "base count width must be even");
   end

   samp_fmt_e   fmt_e;
   logic        pen_q, dma_q, start, hit;
   logic [BASE_W-1:0] base;

   pbk_fmt_decode u_dec (
      .fmt_reg_i   (fmt_reg_i),
      .wide_mode_i (wide_mode_i),
      .rate_hz_o   (rate_hz_o),
      .stereo_o    (stereo_o),
      .sample_fmt_o(fmt_e),
      .byte_shift_o(byte_shift_o),
      .fmt_err_o   (fmt_err_o)
   );
   assign sample_fmt_o = fmt_e;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pen_q <= 1'b0;
         dma_q <= 1'b0;
      end else begin
         pen_q <= play_en_i;
         dma_q <= play_en_i & ~fmt_err_o;
      end
   end

   assign start     = play_en_i & ~pen_q;
   assign dma_req_o = dma_q;
   assign base      = {base_hi_i[HALF_W-1:0], base_lo_i[HALF_W-1:0]};

   pbk_term_counter #(.BASE_W(BASE_W), .CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(start),
      .stb_i  (xfer_stb_i),
      .run_i  (irq_en_i & dma_q),
      .base_i (base),
      .shift_i(byte_shift_o),
      .hit_o  (hit)
   );

   pbk_irq_flags #(.SET_WINS(HIT_SET_WINS)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit_i  (hit),
      .ack_i  (ack_i),
      .wr_i   (flag_wr_i),
      .wr_pi_i(flag_wr_pi_i),
      .int_o  (int_flag_o),
      .pi_o   (pi_flag_o)
   );

   assign irq_o = int_flag_o;

   // R5
   err_drops_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fmt_err_o |=> !dma_req_o);
   // R5
   dma_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req_o |-> $past(play_en_i));
   // R11
   no_hit_without_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dma_req_o |=> !$rose(int_flag_o));
endmodule

// File: tb/pbk_fmt_irq_tb.sv
module pbk_fmt_irq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 20;

   // {wide, fmt byte, rate, stereo, fmt code, err, shift}
   localparam logic [31:0] VEC [NVEC] = '{
      {1'b0, 8'h00, 16'd8000,  1'b0, 3'd0, 1'b0, 2'd0},
      {1'b0, 8'h13, 16'd11025, 1'b1, 3'd0, 1'b0, 2'd1},
      {1'b0, 8'h2C, 16'd48000, 1'b0, 3'd1, 1'b0, 2'd0},
      {1'b0, 8'h7B, 16'd44100, 1'b1, 3'd3, 1'b0, 2'd1},
      {1'b0, 8'h5E, 16'd9000,  1'b1, 3'd2, 1'b0, 2'd2},
      {1'b0, 8'hC2, 16'd16000, 1'b0, 3'd2, 1'b0, 2'd1},
      {1'b1, 8'hC2, 16'd16000, 1'b0, 3'd4, 1'b0, 2'd1},
      {1'b1, 8'hD9, 16'd37800, 1'b1, 3'd4, 1'b0, 2'd2},
      {1'b1, 8'h80, 16'd8000,  1'b0, 3'd7, 1'b1, 2'd0},
      {1'b1, 8'hA0, 16'd8000,  1'b0, 3'd7, 1'b1, 2'd0},
      {1'b1, 8'hE0, 16'd8000,  1'b0, 3'd7, 1'b1, 2'd0},
      {1'b0, 8'h08, 16'd0,     1'b0, 3'd0, 1'b1, 2'd0},
      {1'b0, 8'h0A, 16'd0,     1'b0, 3'd0, 1'b1, 2'd0},
      {1'b1, 8'h1D, 16'd33075, 1'b1, 3'd0, 1'b0, 2'd1},
      {1'b0, 8'h0F, 16'd6620,  1'b0, 3'd0, 1'b0, 2'd0},
      {1'b0, 8'h05, 16'd18900, 1'b0, 3'd0, 1'b0, 2'd0},
      {1'b0, 8'h07, 16'd22050, 1'b0, 3'd0, 1'b0, 2'd0},
      {1'b0, 8'h04, 16'd27420, 1'b0, 3'd0, 1'b0, 2'd0},
      {1'b0, 8'h06, 16'd32000, 1'b0, 3'd0, 1'b0, 2'd0},
      {1'b0, 8'h01, 16'd5510,  1'b0, 3'd0, 1'b0, 2'd0}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic [7:0] fmt_reg = 8'h00;
   logic wide = 1'b0, pen = 1'b0, ien = 1'b0;
   logic [7:0] bhi = 8'h00, blo = 8'h00;
   logic stb = 1'b0, fwr = 1'b0, fpi = 1'b0, ack = 1'b0;
   logic [15:0] rate;
   logic stereo, err, dma, irq, intf, pif;
   logic [2:0] sfmt;
   logic [1:0] shift;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pbk_fmt_irq dut_i (
      .clk(clk), .rst_n(rst_n), .fmt_reg_i(fmt_reg), .wide_mode_i(wide),
      .play_en_i(pen), .irq_en_i(ien), .base_hi_i(bhi), .base_lo_i(blo),
      .xfer_stb_i(stb), .flag_wr_i(fwr), .flag_wr_pi_i(fpi), .ack_i(ack),
      .rate_hz_o(rate), .stereo_o(stereo), .sample_fmt_o(sfmt),
      .byte_shift_o(shift), .fmt_err_o(err), .dma_req_o(dma), .irq_o(irq),
      .int_flag_o(intf), .pi_flag_o(pif)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic strobes(input int n);
      stb = 1'b1;
      repeat (n) tick();
      stb = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12 reset state
      chk("R12", "dma", dma, 0);
      chk("R12", "irq", irq, 0);
      chk("R12", "int", intf, 0);
      chk("R12", "pi", pif, 0);
      rst_n = 1'b1;
      tick();

      // R1 R2 R3 R4 decode table
      for (int i = 0; i < NVEC; i++) begin
         wide = VEC[i][31];
         fmt_reg = VEC[i][30:23];
         #1;
         chk("R1", "rate", rate, VEC[i][22:7]);
         chk("R2", "stereo", stereo, VEC[i][6]);
         chk("R2", "format", sfmt, VEC[i][5:3]);
         chk("R3", "error", err, VEC[i][2]);
         chk("R4", "shift", shift, VEC[i][1:0]);
      end

      // main count: U8 mono, base 3 -> terminal 3
      wide = 1'b0; fmt_reg = 8'h00; bhi = 8'h00; blo = 8'h03; ien = 1'b1; pen = 1'b1;
      tick();
      chk("R5", "dma after enable", dma, 1);
      strobes(2);
      chk("R7", "irq before terminal", irq, 0);
      strobes(1);
      chk("R7", "irq at terminal", irq, 1);
      chk("R7", "int at terminal", intf, 1);
      chk("R7", "pi at terminal", pif, 1);
      ack = 1'b1; tick(); ack = 1'b0;
      chk("R10", "irq after ack", irq, 0);
      chk("R10", "pi after ack", pif, 0);

      // R6 restart clears a partial count
      strobes(2);
      pen = 1'b0; tick();
      chk("R5", "dma after disable", dma, 0);
      pen = 1'b1; tick();
      chk("R5", "dma after re-enable", dma, 1);
      strobes(2);
      chk("R6", "no early irq after restart", irq, 0);
      strobes(1);
      chk("R6", "irq on third after restart", irq, 1);

      // R9 flag writes
      fwr = 1'b1; fpi = 1'b0; tick();
      chk("R9", "irq after PI 1->0", irq, 0);
      chk("R9", "pi after PI 1->0", pif, 0);
      fpi = 1'b1; tick(); fwr = 1'b0;
      chk("R9", "pi after write 1", pif, 1);
      chk("R9", "irq after write 1", irq, 0);
      fwr = 1'b1; fpi = 1'b0; tick(); fwr = 1'b0;

      // R8 strobes ignored while interrupts disabled
      ien = 1'b0;
      strobes(5);
      chk("R8", "irq with IEN clear", irq, 0);
      ien = 1'b1;
      strobes(2);
      chk("R8", "count held, no irq yet", irq, 0);
      strobes(1);
      chk("R8", "irq after held count", irq, 1);
      ack = 1'b1; tick(); ack = 1'b0;

      // R4 R7 stereo 16-bit: base 2 << 2 = 8
      fmt_reg = 8'h50; blo = 8'h02;
      strobes(7);
      chk("R4", "no irq at 7 of 8", irq, 0);
      strobes(1);
      chk("R7", "irq at 8 of 8", irq, 1);
      ack = 1'b1; tick(); ack = 1'b0;

      // R11 zero terminal count
      fmt_reg = 8'h00; blo = 8'h00;
      strobes(4);
      chk("R11", "irq with zero base", irq, 0);

      // R3 R5 rejected code drops DMA
      wide = 1'b1; fmt_reg = 8'hA0; tick();
      chk("R5", "dma with bad code", dma, 0);
      blo = 8'h01;
      strobes(3);
      chk("R11", "irq while dma low", irq, 0);
      wide = 1'b0; fmt_reg = 8'h00; tick();
      chk("R5", "dma after good code", dma, 1);

      // R10 hit beats simultaneous ack (terminal 1)
      stb = 1'b1; ack = 1'b1; tick(); stb = 1'b0; ack = 1'b0;
      chk("R10", "irq when hit meets ack", irq, 1);
      chk("R10", "pi when hit meets ack", pif, 1);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule